// File: doc/BRIEF.md
# Parallel-Load Serial-Out Shift Register with Clock Inhibit

This block turns a parallel byte into a serial bit stream. A level-sensitive shift/load control selects the mode. While it is low, the register captures all parallel inputs. While it is high, the register moves its contents one stage toward the output end on each rising edge of an external shift clock. A serial input fills stage 0 when the register shifts. The serial output is the top stage, so the most significant parallel bit leaves first.

The external shift clock passes through an OR with a clock-inhibit line before the block detects edges. Either line can therefore serve as the enable for the other. Holding the inhibit high freezes shifting.

All logic runs on a free-running system clock. The external shift clock and the inhibit are sampled as data, and a rising edge of their OR is found by comparing the present sample with the previous one. The level load is modelled as a synchronous capture on every system clock edge while the control is low. The control pins are plain levels with no handshake, because the register always accepts a load or a shift in the cycle the condition occurs.

Top module: `piso_shift_reg`

## Requirements
- R1: While `rst_n` is low, every stage clears to 0, so `ser_out` is 0 after reset.
- R2: On every system clock edge where `shift_load` is 0 (load mode), each stage i takes `par_in[i]`, whatever `ext_clk` and `clk_inh` are doing.
- R3: On a system clock edge where `shift_load` is 1 and a shift edge is detected, stage i takes stage i-1, and stage 0 takes `ser_in`.
- R4: `ser_out` is the top stage (index WIDTH-1). After a load it shows `par_in[WIDTH-1]`, and successive shifts present the loaded bits in descending index order down to bit 0.
- R5: While `clk_inh` stays high, toggling `ext_clk` produces no shift, and the register contents are preserved.
- R6: A shift edge is the system clock edge at which `ext_clk | clk_inh` is first sampled high after being sampled low. Holding the OR high for many cycles gives exactly one shift.
- R7: A rising `clk_inh` while `ext_clk` is low is itself a rising edge of the OR and causes one shift. A falling `clk_inh` causes none.
- R8: When `shift_load` is 0 in the same cycle as a shift edge, the load wins and no shift takes place.
- R9: With `shift_load` at 1 and no shift edge, all stages hold their value.
- R10: After WIDTH shifts with `ser_in` held at 0, every stage is 0. A bit presented on `ser_in` reaches `ser_out` after WIDTH shifts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| shift_load | input | 1 | 0 = load parallel inputs, 1 = shift on detected edges |
| ext_clk | input | 1 | External shift clock, sampled as data |
| clk_inh | input | 1 | Clock inhibit, ORed with `ext_clk` |
| ser_in | input | 1 | Bit entering stage 0 on each shift |
| par_in | input | WIDTH | Parallel data, bit WIDTH-1 leaves first |
| ser_out | output | 1 | Top stage of the register |

## Verification
A load or a shift changes the register at the system clock edge that samples the causing condition, and `ser_out` shows the new top stage right after that edge. No further register lies on the path. The bench drives inputs on the falling edge, lets exactly one rising edge pass, and samples `ser_out` on the next falling edge.

For a shift, the edge detector sees the OR rise at that first rising edge, so each external pulse costs one system cycle high and one cycle low. The stall, hold and priority cases are checked at the ports. The bench watches `ser_out` during the stall and then shifts the whole remaining pattern out to prove nothing moved.

// File: rtl/piso_pkg.sv
package piso_pkg;
  typedef enum logic {
    PISO_LOAD  = 1'b0,
    PISO_SHIFT = 1'b1
  } piso_mode_e;
endpackage

// File: rtl/piso_gclk_edge.sv
module piso_gclk_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_clk,
  input  logic clk_inh,
  output logic shift_edge
);
  logic gated;
  logic gated_q;

  assign gated = ext_clk | clk_inh;

  // Reset high so an OR already high at release does not count as an edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gated_q <= 1'b1;
    else        gated_q <= gated;
  end

  assign shift_edge = gated & ~gated_q;

  // R5: inhibit held high across two samples blocks any edge
  a_r5_inhibit_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(clk_inh) && clk_inh) |-> !shift_edge);

  // R6: a level held high yields a single edge
  a_r6_single_edge: assert property (@(posedge clk) disable iff (!rst_n)
    shift_edge |=> !shift_edge);
endmodule

// File: rtl/piso_stage_chain.sv
module piso_stage_chain
  import piso_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  piso_mode_e       mode,
  input  logic             shift_edge,
  input  logic             ser_in,
  input  logic [WIDTH-1:0] par_in,
  output logic [WIDTH-1:0] stages
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_stage
    logic from_below;
    if (i == 0) begin : g_head
      assign from_below = ser_in;
    end else begin : g_body
      assign from_below = stages[i-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 stages[i] <= 1'b0;
      else if (mode == PISO_LOAD) stages[i] <= par_in[i];
      else if (shift_edge)        stages[i] <= from_below;
    end
  end

  // R2, R8: load mode captures the parallel word, even on a shift edge
  a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == PISO_LOAD) |=> stages == $past(par_in));

  // R3: shift moves toward the top and inserts the serial bit
  a_r3_shift: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == PISO_SHIFT && shift_edge) |=>
      stages == {$past(stages[WIDTH-2:0]), $past(ser_in)});

  // R9: no edge in shift mode leaves the register unchanged
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == PISO_SHIFT && !shift_edge) |=> $stable(stages));
endmodule

// File: rtl/piso_shift_reg.sv
module piso_shift_reg
  import piso_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_load,
  input  logic             ext_clk,
  input  logic             clk_inh,
  input  logic             ser_in,
  input  logic [WIDTH-1:0] par_in,
  output logic             ser_out
);
  localparam int TOP = WIDTH - 1;

  logic             shift_edge;
  logic [WIDTH-1:0] stages;
  piso_mode_e       mode;

  assign mode = piso_mode_e'(shift_load);

  piso_gclk_edge u_edge (
    .clk        (clk),
    .rst_n      (rst_n),
    .ext_clk    (ext_clk),
    .clk_inh    (clk_inh),
    .shift_edge (shift_edge)
  );

  piso_stage_chain #(.WIDTH(WIDTH)) u_chain (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode       (mode),
    .shift_edge (shift_edge),
    .ser_in     (ser_in),
    .par_in     (par_in),
    .stages     (stages)
  );

  assign ser_out = stages[TOP];

  // R4: after a load the serial output presents the top parallel bit
  a_r4_top_first: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_load |=> ser_out == $past(par_in[TOP]));
endmodule

// File: tb/piso_shift_reg_tb_top.sv
module piso_shift_reg_tb_top;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         shift_load = 1'b1;
  logic         ext_clk = 1'b0;
  logic         clk_inh = 1'b0;
  logic         ser_in = 1'b0;
  logic [W-1:0] par_in = '0;
  logic         ser_out;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  piso_shift_reg #(.WIDTH(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .shift_load(shift_load), .ext_clk(ext_clk),
    .clk_inh(clk_inh), .ser_in(ser_in), .par_in(par_in), .ser_out(ser_out)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: ser_out=%0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic load(logic [W-1:0] v);
    par_in = v;
    shift_load = 1'b0;
    tick();
    shift_load = 1'b1;
  endtask

  task automatic pulse();
    ext_clk = 1'b1;
    tick();
    ext_clk = 1'b0;
    tick();
  endtask

  task automatic shift_out_check(logic [W-1:0] v, string req);
    for (int i = W - 1; i >= 0; i--) begin
      chk(req, ser_out, v[i]);
      if (i > 0) pulse();
    end
  endtask

  task automatic t_reset();
    chk("R1 reset", ser_out, 1'b0);
  endtask

  task automatic t_basic();
    load(8'hA5);
    chk("R2 load top bit", ser_out, 1'b1);
    shift_out_check(8'hA5, "R4 R3 order");
    load(8'h5A);
    shift_out_check(8'h5A, "R4 second pattern");
  endtask

  task automatic t_zero_fill();
    load(8'hFF);
    ser_in = 1'b0;
    for (int i = 0; i < W; i++) pulse();
    shift_out_check(8'h00, "R10 zero fill");
  endtask

  task automatic t_serial_in();
    logic [W-1:0] pat = 8'h69;
    load(8'h00);
    for (int i = W - 1; i >= 0; i--) begin
      ser_in = pat[i];
      pulse();
    end
    ser_in = 1'b0;
    shift_out_check(pat, "R10 R3 serial input");
  endtask

  task automatic t_load_ignores_clock();
    shift_load = 1'b0;
    par_in = 8'h3C;
    ext_clk = 1'b1; tick();
    ext_clk = 1'b0; tick();
    ext_clk = 1'b1; tick();
    ext_clk = 1'b0;
    par_in = 8'h96; tick();
    shift_load = 1'b1;
    shift_out_check(8'h96, "R2 load ignores ext_clk");
  endtask

  task automatic t_inhibit();
    load(8'hA5);
    clk_inh = 1'b1;          // rising OR while ext_clk low
    tick();
    chk("R7 inhibit rise shifts", ser_out, 1'b0);
    for (int i = 0; i < 3; i++) begin
      pulse();
      chk("R5 inhibit stalls", ser_out, 1'b0);
    end
    clk_inh = 1'b0;          // falling: no shift
    tick();
    chk("R7 inhibit fall no shift", ser_out, 1'b0);
    shift_out_check(8'h4A, "R5 contents kept");
  endtask

  task automatic t_level_high();
    load(8'hA5);
    ext_clk = 1'b1;
    for (int i = 0; i < 5; i++) tick();
    chk("R6 one shift per level", ser_out, 1'b0);
    ext_clk = 1'b0;
    tick();
    shift_out_check(8'h4A, "R6 R9 hold");
  endtask

  task automatic t_priority();
    load(8'h00);
    par_in = 8'hF0;
    shift_load = 1'b0;
    ext_clk = 1'b1;
    tick();
    shift_load = 1'b1;
    tick();
    ext_clk = 1'b0;
    tick();
    shift_out_check(8'hF0, "R8 load beats shift");
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_basic();
    t_zero_fill();
    t_serial_in();
    t_load_ignores_clock();
    t_inhibit();
    t_level_high();
    t_priority();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule